// File: doc/BRIEF.md
# Reorder-Buffer Commit and Squash Controller

This block governs a circular reorder buffer in a small out-of-order core. Instructions enter at the tail through a single dispatch port and are marked finished through a completion port that names the buffer slot. Each cycle the controller retires a bounded run of finished entries from the head, strictly in program order. Entries that must not run speculatively wait until they reach the head. The controller then tells the earlier stages, once, that they may issue that instruction.

Back-end redirect requests arrive on several parallel inputs. The controller picks the oldest valid request. It forwards that request only if it is strictly older than the youngest sequence number still considered live. On acceptance it sends a one-cycle squash broadcast with the boundary sequence number, the corrected target and a mispredict flag. It then pulls the youngest-live register back to the boundary. Squashed entries leave the tail at a bounded rate over several cycles. Retirement and allocation stay frozen until that drain finishes. The free-entry count is always visible, and a one-cycle update strobe marks every cycle in which occupancy changed.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset the buffer is empty: `free_cnt` equals DEPTH, `disp_ready` is 1, and `squash_busy`, `free_upd`, `bc_squash`, `bc_ns_valid` and all `ret_valid` bits are 0.
- R2: A dispatch with `disp_valid` and `disp_ready` both high writes the entry at slot `disp_idx`. After reset `disp_idx` starts at 0 and advances by one modulo DEPTH per allocation. One cycle after any edge that changes occupancy, `free_cnt` shows the new value and `free_upd` is 1 for exactly that cycle.
- R3: `ret_valid[k]` (bit k = slot k, slot 0 is the head) with `ret_seq[k*16 +: 16]` names the entries that retire at the next edge. Up to COMMIT_W entries retire per edge, oldest first. The run stops at the first entry that is not complete.
- R4: When the head entry is non-speculative, live and not complete, `bc_ns_valid` is 1 for one cycle, with `bc_ns_seq` set to that entry's sequence number. This happens exactly once per entry, one edge after the entry reaches the head.
- R5: A completion pulse (`cmp_valid`, `cmp_idx`) marks the named live entry complete. The entry becomes eligible for retirement in the same cycle that follows the edge.
- R6: A redirect is accepted only if its sequence number is strictly smaller than the youngest-live register. That register holds the last dispatched sequence number, or the last accepted redirect if that came later. Equal or larger numbers produce no broadcast.
- R7: Among simultaneously valid redirects, the smallest sequence number wins, and the lower input index wins a tie. One edge after acceptance, `bc_squash` is 1 for one cycle, with that request's sequence number, target and mispredict flag.
- R8: After an acceptance, a later redirect that is equal to or younger than the accepted boundary produces no broadcast.
- R9: While `squash_busy` is 1, at most SQUASH_W entries leave the tail per edge. All of them are younger than the boundary. `squash_busy` falls at the edge that removes the last such entry.
- R10: While `squash_busy` is 1, and in any cycle in which a redirect is being accepted, `disp_ready` is 0 and no `ret_valid` bit is set.
- R11: When all DEPTH entries are occupied, `disp_ready` is 0, and a dispatch attempt leaves `free_cnt` at 0 with no `free_upd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | 16 | Sequence number of the dispatched instruction |
| disp_nonspec | input | 1 | Dispatched instruction must wait for the head |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_idx | output | PTR_W | Slot that the next dispatch will occupy |
| cmp_valid | input | 1 | Completion pulse |
| cmp_idx | input | PTR_W | Slot being marked complete |
| redir_valid | input | NUM_REDIR | Per-input redirect request |
| redir_seq | input | NUM_REDIR*16 | Packed redirect sequence numbers |
| redir_target | input | NUM_REDIR*TGT_W | Packed corrected targets |
| redir_mispred | input | NUM_REDIR | Per-input mispredict flag |
| ret_valid | output | COMMIT_W | Slots retiring at the next edge |
| ret_seq | output | COMMIT_W*16 | Sequence numbers of the retiring slots |
| bc_squash | output | 1 | Squash broadcast strobe |
| bc_squash_seq | output | 16 | Squash boundary: stages discard anything younger |
| bc_target | output | TGT_W | Corrected fetch target |
| bc_mispred | output | 1 | Squash came from a branch mispredict |
| bc_ns_valid | output | 1 | Non-speculative release strobe |
| bc_ns_seq | output | 16 | Sequence number released for issue |
| free_cnt | output | CNT_W | Number of unoccupied slots |
| free_upd | output | 1 | Occupancy changed on the last edge |
| squash_busy | output | 1 | Squash drain in progress |

## Verification
A wrong youngest-live value shows up one edge after the next redirect. The squash strobe either appears where it should be filtered or stays silent where it should fire. A damaged tail pointer or drain count shows in `free_cnt` within a cycle. It also shows in how long `squash_busy` stays high, because the drain length is fixed by how many dispatched entries are younger than the boundary. A lost release bit or done bit shows in the same cycle at `ret_valid`, or one edge later as a missing or repeated `bc_ns_valid` pulse.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int SEQ_W = 16;

  typedef struct packed {
    logic             done;
    logic             nonspec;
    logic             rel;
    logic [SEQ_W-1:0] seq;
  } rob_ent_t;
endpackage

// File: rtl/rcc_entry_store.sv
module rcc_entry_store
  import rcc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic [PTR_W-1:0]      alloc_idx,
  input  logic                  alloc_nonspec,
  input  logic [SEQ_W-1:0]      alloc_seq,
  input  logic                  cmp_en,
  input  logic [PTR_W-1:0]      cmp_idx,
  input  logic                  rel_en,
  input  logic [PTR_W-1:0]      rel_idx,
  output rob_ent_t [DEPTH-1:0]  ents
);
  rob_ent_t [DEPTH-1:0] ents_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents_q <= '0;
    end else begin
      if (alloc_en) begin
        ents_q[alloc_idx].done    <= 1'b0;
        ents_q[alloc_idx].rel     <= 1'b0;
        ents_q[alloc_idx].nonspec <= alloc_nonspec;
        ents_q[alloc_idx].seq     <= alloc_seq;
      end
      if (cmp_en) begin
        ents_q[cmp_idx].done <= 1'b1;
      end
      if (rel_en) begin
        ents_q[rel_idx].rel <= 1'b1;
      end
    end
  end

  assign ents = ents_q;
endmodule

// File: rtl/rcc_redirect_pick.sv
module rcc_redirect_pick
  import rcc_pkg::*;
#(
  parameter int NUM_REDIR = 2,
  parameter int TGT_W     = 32
) (
  input  logic [NUM_REDIR-1:0]       redir_valid,
  input  logic [NUM_REDIR*SEQ_W-1:0] redir_seq,
  input  logic [NUM_REDIR*TGT_W-1:0] redir_target,
  input  logic [NUM_REDIR-1:0]       redir_mispred,
  input  logic [SEQ_W-1:0]           youngest,
  output logic                       accept,
  output logic [SEQ_W-1:0]           sel_seq,
  output logic [TGT_W-1:0]           sel_target,
  output logic                       sel_mispred
);
  logic found;

  // Oldest valid request wins; strict compare keeps the lower index on a tie.
  always_comb begin
    found       = 1'b0;
    sel_seq     = '0;
    sel_target  = '0;
    sel_mispred = 1'b0;
    for (int i = 0; i < NUM_REDIR; i++) begin
      if (redir_valid[i] && (!found || (redir_seq[i*SEQ_W +: SEQ_W] < sel_seq))) begin
        found       = 1'b1;
        sel_seq     = redir_seq[i*SEQ_W +: SEQ_W];
        sel_target  = redir_target[i*TGT_W +: TGT_W];
        sel_mispred = redir_mispred[i];
      end
    end
  end

  // Age filter against the youngest live sequence number.
  assign accept = found && (sel_seq < youngest);
endmodule

// File: rtl/rcc_retire_scan.sv
module rcc_retire_scan #(
  parameter int COMMIT_W = 2,
  localparam int RC_W = $clog2(COMMIT_W + 1)
) (
  input  logic [COMMIT_W-1:0] live,
  input  logic [COMMIT_W-1:0] done,
  output logic [COMMIT_W-1:0] mask,
  output logic [RC_W-1:0]     cnt
);
  logic go;

  always_comb begin
    go   = 1'b1;
    mask = '0;
    cnt  = '0;
    for (int k = 0; k < COMMIT_W; k++) begin
      if (go && live[k] && done[k]) begin
        mask[k] = 1'b1;
        cnt     = cnt + RC_W'(1);
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rcc_squash_scan.sv
module rcc_squash_scan #(
  parameter int SQUASH_W = 2,
  localparam int KC_W = $clog2(SQUASH_W + 1)
) (
  input  logic [SQUASH_W:0] live,
  input  logic [SQUASH_W:0] younger,
  output logic [KC_W-1:0]   kill,
  output logic              clear
);
  logic go;

  // Window slot j is the j-th entry counted back from the tail.
  // Slot SQUASH_W is only probed to learn whether the drain ends now.
  always_comb begin
    go   = 1'b1;
    kill = '0;
    for (int j = 0; j < SQUASH_W; j++) begin
      if (go && live[j] && younger[j]) begin
        kill = kill + KC_W'(1);
      end else begin
        go = 1'b0;
      end
    end
    clear = !(go && live[SQUASH_W] && younger[SQUASH_W]);
  end
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rcc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int COMMIT_W  = 2,
  parameter int SQUASH_W  = 2,
  parameter int NUM_REDIR = 2,
  parameter int TGT_W     = 32,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = PTR_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  input  logic [15:0]                disp_seq,
  input  logic                       disp_nonspec,
  output logic                       disp_ready,
  output logic [PTR_W-1:0]           disp_idx,
  input  logic                       cmp_valid,
  input  logic [PTR_W-1:0]           cmp_idx,
  input  logic [NUM_REDIR-1:0]       redir_valid,
  input  logic [NUM_REDIR*16-1:0]    redir_seq,
  input  logic [NUM_REDIR*TGT_W-1:0] redir_target,
  input  logic [NUM_REDIR-1:0]       redir_mispred,
  output logic [COMMIT_W-1:0]        ret_valid,
  output logic [COMMIT_W*16-1:0]     ret_seq,
  output logic                       bc_squash,
  output logic [15:0]                bc_squash_seq,
  output logic [TGT_W-1:0]           bc_target,
  output logic                       bc_mispred,
  output logic                       bc_ns_valid,
  output logic [15:0]                bc_ns_seq,
  output logic [CNT_W-1:0]           free_cnt,
  output logic                       free_upd,
  output logic                       squash_busy
);
  localparam int RC_W = $clog2(COMMIT_W + 1);
  localparam int KC_W = $clog2(SQUASH_W + 1);

  // ---------------- state ----------------
  logic [PTR_W-1:0] head_q, tail_q, head_n, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SEQ_W-1:0] young_q, young_n;
  logic             sq_q, sq_n;
  logic [SEQ_W-1:0] bound_q, bound_n;

  logic             bcs_q, bcm_q, bcn_q, fupd_q;
  logic [SEQ_W-1:0] bcs_seq_q, bcn_seq_q;
  logic [TGT_W-1:0] bct_q;

  rob_ent_t [DEPTH-1:0] ents;

  // ---------------- redirect selection ----------------
  logic             acc;
  logic [SEQ_W-1:0] sel_seq;
  logic [TGT_W-1:0] sel_tgt;
  logic             sel_mp;

  rcc_redirect_pick #(.NUM_REDIR(NUM_REDIR), .TGT_W(TGT_W)) u_pick (
    .redir_valid   (redir_valid),
    .redir_seq     (redir_seq),
    .redir_target  (redir_target),
    .redir_mispred (redir_mispred),
    .youngest      (young_q),
    .accept        (acc),
    .sel_seq       (sel_seq),
    .sel_target    (sel_tgt),
    .sel_mispred   (sel_mp)
  );

  // ---------------- head window / retire ----------------
  logic [COMMIT_W-1:0] rw_live, rw_done, rw_mask;
  logic [RC_W-1:0]     rw_cnt;
  logic                ret_en;

  always_comb begin
    for (int k = 0; k < COMMIT_W; k++) begin
      rw_live[k] = CNT_W'(k) < cnt_q;
      rw_done[k] = ents[head_q + PTR_W'(k)].done;
      ret_seq[k*SEQ_W +: SEQ_W] = ents[head_q + PTR_W'(k)].seq;
    end
  end

  rcc_retire_scan #(.COMMIT_W(COMMIT_W)) u_ret (
    .live (rw_live),
    .done (rw_done),
    .mask (rw_mask),
    .cnt  (rw_cnt)
  );

  assign ret_en    = !sq_q && !acc;
  assign ret_valid = ret_en ? rw_mask : '0;

  // ---------------- tail window / squash drain ----------------
  logic [SQUASH_W:0] sw_live, sw_young;
  logic [KC_W-1:0]   sw_kill;
  logic              sw_clear;

  always_comb begin
    for (int j = 0; j <= SQUASH_W; j++) begin
      sw_live[j]  = CNT_W'(j) < cnt_q;
      sw_young[j] = ents[tail_q - PTR_W'(j + 1)].seq > bound_q;
    end
  end

  rcc_squash_scan #(.SQUASH_W(SQUASH_W)) u_sq (
    .live    (sw_live),
    .younger (sw_young),
    .kill    (sw_kill),
    .clear   (sw_clear)
  );

  // ---------------- dispatch / completion / release ----------------
  logic     alloc, cmp_live, ns_fire;
  rob_ent_t head_ent;
  logic [RC_W-1:0] r_n;
  logic [KC_W-1:0] k_n;

  assign head_ent   = ents[head_q];
  assign disp_ready = (cnt_q < CNT_W'(DEPTH)) && !sq_q && !acc;
  assign alloc      = disp_valid && disp_ready;
  assign disp_idx   = tail_q;
  assign cmp_live   = cmp_valid && ({1'b0, PTR_W'(cmp_idx - head_q)} < cnt_q);
  assign ns_fire    = (cnt_q != '0) && head_ent.nonspec && !head_ent.done &&
                      !head_ent.rel && !sq_q && !acc;

  rcc_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_en      (alloc),
    .alloc_idx     (tail_q),
    .alloc_nonspec (disp_nonspec),
    .alloc_seq     (disp_seq),
    .cmp_en        (cmp_live),
    .cmp_idx       (cmp_idx),
    .rel_en        (ns_fire),
    .rel_idx       (head_q),
    .ents          (ents)
  );

  // ---------------- next state ----------------
  always_comb begin
    r_n     = ret_en ? rw_cnt : '0;
    k_n     = sq_q ? sw_kill : '0;
    head_n  = head_q + PTR_W'(r_n);
    tail_n  = tail_q + PTR_W'(alloc) - PTR_W'(k_n);
    cnt_n   = cnt_q + CNT_W'(alloc) - CNT_W'(r_n) - CNT_W'(k_n);
    young_n = young_q;
    if (acc) begin
      young_n = sel_seq;
    end else if (alloc) begin
      young_n = disp_seq;
    end
    sq_n    = acc || (sq_q && !sw_clear);
    bound_n = acc ? sel_seq : bound_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
      young_q   <= '0;
      sq_q      <= 1'b0;
      bound_q   <= '0;
      bcs_q     <= 1'b0;
      bcs_seq_q <= '0;
      bct_q     <= '0;
      bcm_q     <= 1'b0;
      bcn_q     <= 1'b0;
      bcn_seq_q <= '0;
      fupd_q    <= 1'b0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      cnt_q   <= cnt_n;
      young_q <= young_n;
      sq_q    <= sq_n;
      bound_q <= bound_n;
      bcs_q   <= acc;
      if (acc) begin
        bcs_seq_q <= sel_seq;
        bct_q     <= sel_tgt;
        bcm_q     <= sel_mp;
      end
      bcn_q <= ns_fire;
      if (ns_fire) begin
        bcn_seq_q <= head_ent.seq;
      end
      fupd_q <= (cnt_n != cnt_q);
    end
  end

  assign bc_squash     = bcs_q;
  assign bc_squash_seq = bcs_seq_q;
  assign bc_target     = bct_q;
  assign bc_mispred    = bcm_q;
  assign bc_ns_valid   = bcn_q;
  assign bc_ns_seq     = bcn_seq_q;
  assign free_cnt      = CNT_W'(DEPTH) - cnt_q;
  assign free_upd      = fupd_q;
  assign squash_busy   = sq_q;

  // ---------------- assertions ----------------
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  a_r10_no_retire_in_squash: assert property (@(posedge clk) disable iff (!rst_n)
    sq_q |-> (ret_valid == '0));

  a_r10_no_dispatch_in_squash: assert property (@(posedge clk) disable iff (!rst_n)
    sq_q |-> !disp_ready);

  a_r6_bcast_older: assert property (@(posedge clk) disable iff (!rst_n)
    bcs_q |-> (bcs_seq_q < $past(young_q)));

  a_r9_drain_rate: assert property (@(posedge clk) disable iff (!rst_n)
    sq_q |=> ((32'(cnt_q) + SQUASH_W) >= 32'($past(cnt_q))));

  a_r4_release_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    bcn_q |-> ($past(cnt_q) != '0));

  a_r3_in_order_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid & (ret_valid + COMMIT_W'(1))) == '0));
endmodule

// File: tb/rob_commit_ctrl_tb_top.sv
module rob_commit_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CW    = 2;
  localparam int NR    = 2;
  localparam int TW    = 32;
  localparam logic [31:0] TGT0 = 32'hA000_0010;
  localparam logic [31:0] TGT1 = 32'hB000_0020;

  typedef struct packed {
    logic        v0;
    logic [15:0] s0;
    logic        v1;
    logic [15:0] s1;
    logic        acc;
    logic [15:0] bseq;
    logic        sel;
    logic [3:0]  free;
  } vec_t;

  // Setup per row: reset, dispatch seqs 10,20,30,40; then one redirect cycle.
  localparam vec_t VECS [8] = '{
    '{1'b1, 16'd25, 1'b0, 16'd0,  1'b1, 16'd25, 1'b0, 4'd6},
    '{1'b1, 16'd35, 1'b1, 16'd15, 1'b1, 16'd15, 1'b1, 4'd7},
    '{1'b1, 16'd40, 1'b0, 16'd0,  1'b0, 16'd0,  1'b0, 4'd4},
    '{1'b1, 16'd50, 1'b0, 16'd0,  1'b0, 16'd0,  1'b0, 4'd4},
    '{1'b0, 16'd5,  1'b0, 16'd3,  1'b0, 16'd0,  1'b0, 4'd4},
    '{1'b0, 16'd0,  1'b1, 16'd10, 1'b1, 16'd10, 1'b1, 4'd7},
    '{1'b1, 16'd5,  1'b1, 16'd30, 1'b1, 16'd5,  1'b0, 4'd8},
    '{1'b1, 16'd20, 1'b1, 16'd20, 1'b1, 16'd20, 1'b0, 4'd6}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           disp_valid, disp_nonspec, disp_ready;
  logic [15:0]    disp_seq;
  logic [2:0]     disp_idx, cmp_idx;
  logic           cmp_valid;
  logic [NR-1:0]  redir_valid, redir_mispred;
  logic [NR*16-1:0] redir_seq;
  logic [NR*TW-1:0] redir_target;
  logic [CW-1:0]  ret_valid;
  logic [CW*16-1:0] ret_seq;
  logic           bc_squash, bc_mispred, bc_ns_valid, free_upd, squash_busy;
  logic [15:0]    bc_squash_seq, bc_ns_seq;
  logic [TW-1:0]  bc_target;
  logic [3:0]     free_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_commit_ctrl #(.DEPTH(DEPTH), .COMMIT_W(CW), .SQUASH_W(2), .NUM_REDIR(NR), .TGT_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_seq(disp_seq), .disp_nonspec(disp_nonspec),
    .disp_ready(disp_ready), .disp_idx(disp_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .redir_valid(redir_valid), .redir_seq(redir_seq),
    .redir_target(redir_target), .redir_mispred(redir_mispred),
    .ret_valid(ret_valid), .ret_seq(ret_seq),
    .bc_squash(bc_squash), .bc_squash_seq(bc_squash_seq),
    .bc_target(bc_target), .bc_mispred(bc_mispred),
    .bc_ns_valid(bc_ns_valid), .bc_ns_seq(bc_ns_seq),
    .free_cnt(free_cnt), .free_upd(free_upd), .squash_busy(squash_busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    disp_valid = 1'b0; disp_seq = '0; disp_nonspec = 1'b0;
    cmp_valid = 1'b0; cmp_idx = '0;
    redir_valid = '0; redir_seq = '0; redir_mispred = 2'b01;
    redir_target = {TGT1, TGT0};
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic dispatch(input logic [15:0] s, input logic ns);
    disp_valid = 1'b1; disp_seq = s; disp_nonspec = ns;
    tick();
    disp_valid = 1'b0; disp_nonspec = 1'b0;
  endtask

  task automatic complete(input logic [2:0] idx);
    cmp_valid = 1'b1; cmp_idx = idx;
    tick();
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    // ---- R1: reset state ----
    chk("R1 free_cnt", free_cnt, 8);
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 busy/bcast/upd", {squash_busy, bc_squash, bc_ns_valid, free_upd}, 0);
    chk("R1 ret_valid", ret_valid, 0);

    // ---- R2: allocation order and free count ----
    for (int i = 0; i < 3; i++) begin
      disp_valid = 1'b1; disp_seq = 16'(100 + i);
      #1 chk("R2 disp_idx", disp_idx, i);
      tick();
    end
    disp_valid = 1'b0;
    chk("R2 free_cnt after 3", free_cnt, 5);
    chk("R2 free_upd pulse", free_upd, 1);
    tick();
    chk("R2 free_upd clears", free_upd, 0);

    // ---- R3/R5: in-order retirement stops at incomplete entry ----
    complete(3'd0);
    chk("R5 done head retires", ret_valid, 2'b01);
    chk("R3 slot0 seq", ret_seq[15:0], 100);
    complete(3'd2);
    chk("R3 stop at incomplete", ret_valid, 2'b00);
    chk("R3 free after one retire", free_cnt, 6);
    complete(3'd1);
    chk("R3 two retire in order", ret_valid, 2'b11);
    chk("R3 two seqs", ret_seq, {16'd102, 16'd101});
    tick();
    chk("R3 empty again", free_cnt, 8);

    // ---- R4: non-speculative release at head ----
    dispatch(16'd200, 1'b1);
    chk("R4 no release yet", bc_ns_valid, 0);
    tick();
    chk("R4 release strobe", bc_ns_valid, 1);
    chk("R4 release seq", bc_ns_seq, 200);
    chk("R4 held until done", ret_valid, 0);
    tick();
    chk("R4 released once", bc_ns_valid, 0);
    complete(3'd3);
    chk("R4 retires after done", ret_valid, 2'b01);
    tick();

    // ---- R11: full buffer ----
    for (int i = 0; i < 8; i++) dispatch(16'(300 + i), 1'b0);
    chk("R11 free zero", free_cnt, 0);
    chk("R11 ready low", disp_ready, 0);
    disp_valid = 1'b1; disp_seq = 16'd999;
    tick();
    disp_valid = 1'b0;
    chk("R11 dispatch ignored", free_cnt, 0);
    chk("R11 no update", free_upd, 0);
    for (int i = 0; i < 8; i++) complete(3'((4 + i) % 8));
    repeat (4) tick();
    chk("R11 drained by retire", free_cnt, 8);

    // ---- R8/R9/R10: bounded drain, freeze, stale redirect ----
    do_reset();
    for (int i = 1; i <= 4; i++) dispatch(16'(10 * i), 1'b0);
    cmp_valid = 1'b1; cmp_idx = 3'd0;
    redir_valid = 2'b01; redir_seq = {16'd0, 16'd15};
    #1 chk("R10 ready low on accept", disp_ready, 0);
    chk("R10 no retire on accept", ret_valid, 0);
    tick();
    cmp_valid = 1'b0;
    chk("R7 squash strobe", bc_squash, 1);
    chk("R9 busy", squash_busy, 1);
    chk("R9 free before drain", free_cnt, 4);
    chk("R10 retire frozen", ret_valid, 0);
    chk("R10 ready frozen", disp_ready, 0);
    redir_valid = 2'b01; redir_seq = {16'd0, 16'd18};
    tick();
    redir_valid = '0;
    chk("R8 younger redirect dropped", bc_squash, 0);
    chk("R9 still busy", squash_busy, 1);
    chk("R9 two removed", free_cnt, 6);
    tick();
    chk("R9 drain done", squash_busy, 0);
    chk("R9 survivor count", free_cnt, 7);
    chk("R3 retire resumes", ret_valid, 2'b01);
    chk("R3 survivor seq", ret_seq[15:0], 10);
    tick();

    // ---- R6/R7: redirect table ----
    for (int r = 0; r < 8; r++) begin
      do_reset();
      for (int i = 1; i <= 4; i++) dispatch(16'(10 * i), 1'b0);
      redir_valid = {VECS[r].v1, VECS[r].v0};
      redir_seq   = {VECS[r].s1, VECS[r].s0};
      tick();
      redir_valid = '0;
      chk("R6 accept", bc_squash, VECS[r].acc);
      if (VECS[r].acc) begin
        chk("R7 boundary", bc_squash_seq, VECS[r].bseq);
        chk("R7 target", bc_target, VECS[r].sel ? TGT1 : TGT0);
        chk("R7 mispredict", bc_mispred, !VECS[r].sel);
      end
      for (int w = 0; w < 10 && squash_busy; w++) tick();
      chk("R9 final free", free_cnt, VECS[r].free);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule